// File: doc/BRIEF.md
# Variable-Range Translation Cache with Pinned Slots

This block is a small, fully associative address translation cache. Each entry covers a contiguous virtual range and maps it onto a physical base. A normal entry spans one 4 KB page times a power of four. A lookup port runs alongside a command port. A lookup returns a hit flag, the translated physical address and the protection fields of the entry that matched. Permission checking and table walking are left to the logic around the block.

The lowest-numbered slots are pinned. Ordinary inserts and purges never remove a pinned slot. Only a forced ranged purge, or a slot-addressed command, can write or clear one. The remaining slots are filled from a free set, taking the lowest free slot first. When no slot is free, a round-robin pointer picks the victim. This pointer visits only the unpinned slots.

An insert first clears every unpinned entry whose range overlaps the new range. It writes the new entry one cycle later, so the slot chosen for it can be one that the purge has just freed. All other commands complete in a single cycle.

Top module: `rtlb_top`

## Requirements
- R1: A lookup requested in one cycle is answered in the next cycle with `lk_ack`. `lk_hit` is 1 when a valid entry satisfies start ≤ address ≤ last, and `lk_pa` = base + (address − start). On a miss, `lk_hit`, `lk_pa` and `lk_prot` are 0.
- R2: When several entries match an address, the entry in the lowest-numbered slot supplies the result. This means a pinned slot wins over an unpinned one.
- R3: An insert (op 1) covers `4096 << (2*cmd_opa[3:0])` bytes. Its start is `cmd_addr` aligned down to that size. Its physical base is `cmd_opa << 7` masked to the same alignment.
- R4: `lk_prot` packs, MSB first, the write-data bits 61, 60, 59, [58:56], [55:54], [53:52], 51 and [31:1] of `cmd_opb`. These are taken from the insert or pinned-write command that created the entry.
- R5: Before an insert writes its entry, every unpinned entry that overlaps the new range is invalidated. Pinned entries are kept.
- R6: An insert takes the lowest-numbered free unpinned slot. When none is free, it replaces the slot under a round-robin pointer. The pointer starts at the first unpinned slot, advances after each such replacement, and wraps from the last slot back to the first unpinned slot.
- R7: A ranged purge (op 2) starts at `cmd_addr` aligned down to a page. It spans `4096 << (2*cmd_addr[3:0])` bytes and invalidates every overlapping entry. A pinned entry is invalidated only when `cmd_force` is 1.
- R8: Purge-all (op 3) invalidates every unpinned slot, keeps the pinned ones, and returns the round-robin pointer to the first unpinned slot.
- R9: A pinned write (op 4) fills slot `cmd_slot`. The virtual page number is `cmd_addr`, the physical page number is `cmd_opa`, and the range is `cmd_len` pages long. If the slot is not pinned, or `cmd_len` is 0, the status is 1 and nothing changes.
- R10: A pinned purge (op 5) invalidates slot `cmd_slot`. If the slot is not pinned, the status is 1 and nothing changes.
- R11: Op 0 does nothing and gives no response. Ops 6 and 7 answer with status 2 and change nothing. Status 0 means success.
- R12: For a single-cycle command, `rsp_valid` pulses in the cycle after the command is accepted. For an insert, `cmd_busy` is high in that cycle and `rsp_valid` pulses one cycle later. A command presented while `cmd_busy` is high is ignored.
- R13: After reset, every slot is invalid, and `cmd_busy`, `rsp_valid` and `lk_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | VA_W | Virtual address, or virtual page number for a pinned write |
| cmd_opa | input | 64 | Size/physical operand, or physical page number for a pinned write |
| cmd_opb | input | 64 | Protection word |
| cmd_force | input | 1 | Lets a ranged purge clear pinned entries |
| cmd_slot | input | IDX_W | Slot index for pinned commands |
| cmd_len | input | LEN_W | Pinned range length in pages |
| cmd_busy | output | 1 | Insert in its write step; commands are ignored |
| rsp_valid | output | 1 | Command completed |
| rsp_status | output | 2 | 0 ok, 1 bad argument, 2 unknown op |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | VA_W | Lookup virtual address |
| lk_ack | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | Lookup matched |
| lk_pa | output | PA_W | Translated physical address |
| lk_prot | output | 42 | Protection fields of the matching entry |

## Verification
The hardest state to reach is the one where every unpinned slot is valid, so that the round-robin pointer chooses the victim instead of the free set. Reaching it a second time after a purge-all shows whether the pointer was reset. The bench fills all twelve unpinned slots with distinct pages and inserts beyond that. It then uses lookups to find which page disappeared, repeats this after a purge-all, and finishes with a multi-page ranged purge. A second hard case is a command that arrives during the write step of an insert. The bench drives a purge-all exactly in that cycle, then confirms that the entries are still there.

// File: rtl/rtlb_pkg.sv
`timescale 1ns/1ps
package rtlb_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_INSERT    = 3'd1,
    OP_PURGE     = 3'd2,
    OP_PURGE_ALL = 3'd3,
    OP_PIN_WRITE = 3'd4,
    OP_PIN_PURGE = 3'd5,
    OP_RSV6      = 3'd6,
    OP_RSV7      = 3'd7
  } op_e;

  localparam logic [1:0] ST_OK     = 2'd0;
  localparam logic [1:0] ST_BADARG = 2'd1;
  localparam logic [1:0] ST_BADOP  = 2'd2;

  typedef struct packed {
    logic        ref_trap;
    logic        dirty;
    logic        brk_wr;
    logic [2:0]  acc_type;
    logic [1:0]  priv_a;
    logic [1:0]  priv_b;
    logic        uncache;
    logic [30:0] acc_id;
  } prot_t;

  localparam int PROT_W = $bits(prot_t);

  function automatic prot_t prot_from_word(input logic [63:0] w);
    prot_t p;
    p.ref_trap = w[61];
    p.dirty    = w[60];
    p.brk_wr   = w[59];
    p.acc_type = w[58:56];
    p.priv_a   = w[55:54];
    p.priv_b   = w[53:52];
    p.uncache  = w[51];
    p.acc_id   = w[31:1];
    return p;
  endfunction

endpackage

// File: rtl/rtlb_match.sv
`timescale 1ns/1ps
module rtlb_match #(
  parameter int N_ENT = 16,
  parameter int VA_W  = 64,
  parameter int IDX_W = 4
) (
  input  logic [N_ENT-1:0]           vld,
  input  logic [N_ENT-1:0][VA_W-1:0] lo,
  input  logic [N_ENT-1:0][VA_W-1:0] hi,
  input  logic [VA_W-1:0]            q_addr,
  input  logic [VA_W-1:0]            r_lo,
  input  logic [VA_W-1:0]            r_hi,
  output logic                       q_any,
  output logic [IDX_W-1:0]           q_idx,
  output logic [N_ENT-1:0]           ovl
);

  logic [N_ENT-1:0] hit_v;

  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_cmp
      assign hit_v[g] = vld[g] && (lo[g] <= q_addr) && (q_addr <= hi[g]);
      assign ovl[g]   = vld[g] && (lo[g] <= r_hi) && (r_lo <= hi[g]);
    end
  endgenerate

  assign q_any = |hit_v;

  always_comb begin
    q_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_v[i]) q_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/rtlb_alloc.sv
`timescale 1ns/1ps
module rtlb_alloc #(
  parameter int N_ENT  = 16,
  parameter int N_LOCK = 4,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_ENT-1:0] vld,
  input  logic             adv,
  input  logic             restart,
  output logic [IDX_W-1:0] victim,
  output logic             from_rr,
  output logic [IDX_W-1:0] rr_ptr
);

  localparam logic [IDX_W-1:0] FIRST_FREE = IDX_W'(N_LOCK);
  localparam logic [IDX_W-1:0] LAST_SLOT  = IDX_W'(N_ENT - 1);

  logic [N_ENT-1:0] free_v;
  logic [IDX_W-1:0] low_free;

  genvar g;
  generate
    for (g = 0; g < N_ENT; g++) begin : g_free
      if (g < N_LOCK) begin : g_pin
        assign free_v[g] = 1'b0;
      end else begin : g_open
        assign free_v[g] = ~vld[g];
      end
    end
  endgenerate

  always_comb begin
    low_free = FIRST_FREE;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (free_v[i]) low_free = IDX_W'(i);
    end
  end

  assign from_rr = ~|free_v;
  assign victim  = from_rr ? rr_ptr : low_free;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      rr_ptr <= FIRST_FREE;
    end else if (adv) begin
      rr_ptr <= (rr_ptr == LAST_SLOT) ? FIRST_FREE : rr_ptr + 1'b1;
    end
  end

endmodule

// File: rtl/rtlb_top.sv
`timescale 1ns/1ps
module rtlb_top
  import rtlb_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int N_LOCK = 4,
  parameter int VA_W   = 64,
  parameter int PA_W   = 64,
  parameter int PG_SH  = 12,
  parameter int LEN_W  = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_addr,
  input  logic [63:0]       cmd_opa,
  input  logic [63:0]       cmd_opb,
  input  logic              cmd_force,
  input  logic [IDX_W-1:0]  cmd_slot,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_addr,
  output logic              lk_ack,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [PROT_W-1:0] lk_prot
);

  localparam logic [VA_W-1:0] VONE = VA_W'(1);
  localparam logic [PA_W-1:0] PONE = PA_W'(1);
  localparam logic [VA_W-1:0] PG_OFS = (VONE << PG_SH) - VONE;

  typedef enum logic {S_IDLE, S_FILL} st_e;

  st_e state;

  // entry storage
  logic [N_ENT-1:0]           e_vld;
  logic [N_ENT-1:0][VA_W-1:0] e_lo;
  logic [N_ENT-1:0][VA_W-1:0] e_hi;
  logic [N_ENT-1:0][PA_W-1:0] e_base;
  prot_t                      e_prot [N_ENT];

  // insert held between purge step and write step
  logic [VA_W-1:0] f_lo, f_hi;
  logic [PA_W-1:0] f_base;
  prot_t           f_prot;

  // decoded command ranges
  logic [6:0]      ins_sh, prg_sh;
  logic [VA_W-1:0] ins_span, ins_lo, ins_hi;
  logic [PA_W-1:0] pa_span, ins_base;
  logic [63:0]     opa_sh;
  logic [VA_W-1:0] prg_span, prg_lo, prg_hi;
  logic [VA_W-1:0] pin_lo, pin_hi;
  logic [PA_W-1:0] pin_base;
  logic [VA_W-1:0] r_lo, r_hi;
  prot_t           cmd_prot;

  logic            accept, fill, slot_pin, pin_ok;
  logic            q_any;
  logic [IDX_W-1:0] q_idx;
  logic [N_ENT-1:0] ovl;
  logic [IDX_W-1:0] victim, rr_ptr;
  logic            from_rr;

  assign fill     = (state == S_FILL);
  assign cmd_busy = fill;
  assign accept   = cmd_valid && (state == S_IDLE);
  assign slot_pin = (int'(cmd_slot) < N_LOCK);
  assign pin_ok   = slot_pin && (cmd_len != '0);
  assign cmd_prot = prot_from_word(cmd_opb);

  always_comb begin
    ins_sh   = 7'(PG_SH) + {2'b00, cmd_opa[3:0], 1'b0};
    ins_span = VONE << ins_sh;
    ins_lo   = cmd_addr & ~(ins_span - VONE);
    ins_hi   = ins_lo + ins_span - VONE;
    pa_span  = PONE << ins_sh;
    opa_sh   = cmd_opa << 7;
    ins_base = PA_W'(opa_sh) & ~(pa_span - PONE);

    prg_sh   = 7'(PG_SH) + {2'b00, cmd_addr[3:0], 1'b0};
    prg_span = VONE << prg_sh;
    prg_lo   = cmd_addr & ~PG_OFS;
    prg_hi   = prg_lo + prg_span - VONE;

    pin_lo   = cmd_addr << PG_SH;
    pin_hi   = pin_lo + (VA_W'(cmd_len) << PG_SH) - VONE;
    pin_base = PA_W'(cmd_opa) << PG_SH;

    if (cmd_op == OP_INSERT) begin
      r_lo = ins_lo;
      r_hi = ins_hi;
    end else begin
      r_lo = prg_lo;
      r_hi = prg_hi;
    end
  end

  rtlb_match #(.N_ENT(N_ENT), .VA_W(VA_W), .IDX_W(IDX_W)) u_match (
    .vld    (e_vld),
    .lo     (e_lo),
    .hi     (e_hi),
    .q_addr (lk_addr),
    .r_lo   (r_lo),
    .r_hi   (r_hi),
    .q_any  (q_any),
    .q_idx  (q_idx),
    .ovl    (ovl)
  );

  rtlb_alloc #(.N_ENT(N_ENT), .N_LOCK(N_LOCK), .IDX_W(IDX_W)) u_alloc (
    .clk     (clk),
    .rst     (rst),
    .vld     (e_vld),
    .adv     (fill && from_rr),
    .restart (accept && (cmd_op == OP_PURGE_ALL)),
    .victim  (victim),
    .from_rr (from_rr),
    .rr_ptr  (rr_ptr)
  );

  // control, valid bits and response
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      e_vld      <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      if (fill) begin
        e_vld[victim] <= 1'b1;
        state         <= S_IDLE;
        rsp_valid     <= 1'b1;
      end else if (accept) begin
        case (cmd_op)
          OP_NOP: ;
          OP_INSERT: begin
            for (int i = N_LOCK; i < N_ENT; i++) begin
              if (ovl[i]) e_vld[i] <= 1'b0;
            end
            state <= S_FILL;
          end
          OP_PURGE: begin
            for (int i = 0; i < N_ENT; i++) begin
              if (ovl[i] && (i >= N_LOCK || cmd_force)) e_vld[i] <= 1'b0;
            end
            rsp_valid <= 1'b1;
          end
          OP_PURGE_ALL: begin
            for (int i = N_LOCK; i < N_ENT; i++) e_vld[i] <= 1'b0;
            rsp_valid <= 1'b1;
          end
          OP_PIN_WRITE: begin
            if (pin_ok) e_vld[cmd_slot] <= 1'b1;
            else        rsp_status <= ST_BADARG;
            rsp_valid <= 1'b1;
          end
          OP_PIN_PURGE: begin
            if (slot_pin) e_vld[cmd_slot] <= 1'b0;
            else          rsp_status <= ST_BADARG;
            rsp_valid <= 1'b1;
          end
          default: begin
            rsp_status <= ST_BADOP;
            rsp_valid  <= 1'b1;
          end
        endcase
      end
    end
  end

  // entry data, no reset needed (guarded by valid bits)
  always_ff @(posedge clk) begin
    if (accept && cmd_op == OP_INSERT) begin
      f_lo   <= ins_lo;
      f_hi   <= ins_hi;
      f_base <= ins_base;
      f_prot <= cmd_prot;
    end
    if (fill) begin
      e_lo[victim]   <= f_lo;
      e_hi[victim]   <= f_hi;
      e_base[victim] <= f_base;
      e_prot[victim] <= f_prot;
    end else if (accept && cmd_op == OP_PIN_WRITE && pin_ok) begin
      e_lo[cmd_slot]   <= pin_lo;
      e_hi[cmd_slot]   <= pin_hi;
      e_base[cmd_slot] <= pin_base;
      e_prot[cmd_slot] <= cmd_prot;
    end
  end

  // registered lookup result
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_ack  <= 1'b0;
      lk_hit  <= 1'b0;
      lk_pa   <= '0;
      lk_prot <= '0;
    end else begin
      lk_ack <= lk_req;
      if (lk_req && q_any) begin
        lk_hit  <= 1'b1;
        lk_pa   <= e_base[q_idx] + PA_W'(lk_addr - e_lo[q_idx]);
        lk_prot <= e_prot[q_idx];
      end else begin
        lk_hit  <= 1'b0;
        lk_pa   <= '0;
        lk_prot <= '0;
      end
    end
  end

endmodule

// File: rtl/rtlb_chk.sv
`timescale 1ns/1ps
module rtlb_chk #(
  parameter int N_ENT  = 16,
  parameter int N_LOCK = 4,
  parameter int PA_W   = 64,
  parameter int IDX_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_slot,
  input logic             cmd_busy,
  input logic             rsp_valid,
  input logic [1:0]       rsp_status,
  input logic             lk_ack,
  input logic             lk_hit,
  input logic [PA_W-1:0]  lk_pa,
  input logic [IDX_W-1:0] rr_ptr,
  input logic [IDX_W-1:0] victim,
  input logic             fill
);

  logic taken;
  assign taken = cmd_valid && !cmd_busy;

  a_r12_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cmd_busy |=> !cmd_busy);

  a_r12_busy_then_rsp: assert property (@(posedge clk) disable iff (rst)
    cmd_busy |=> rsp_valid);

  a_r12_insert_waits: assert property (@(posedge clk) disable iff (rst)
    (taken && cmd_op == 3'd1) |=> (cmd_busy && !rsp_valid));

  a_r11_bad_op: assert property (@(posedge clk) disable iff (rst)
    (taken && cmd_op >= 3'd6) |=> (rsp_valid && rsp_status == 2'd2));

  a_r9_bad_slot: assert property (@(posedge clk) disable iff (rst)
    (taken && (cmd_op == 3'd4 || cmd_op == 3'd5) && int'(cmd_slot) >= N_LOCK)
      |=> (rsp_valid && rsp_status == 2'd1));

  a_r6_victim_unpinned: assert property (@(posedge clk) disable iff (rst)
    fill |-> (int'(victim) >= N_LOCK));

  a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
    (int'(rr_ptr) >= N_LOCK) && (int'(rr_ptr) < N_ENT));

  a_r8_ptr_restart: assert property (@(posedge clk) disable iff (rst)
    (taken && cmd_op == 3'd3) |=> (int'(rr_ptr) == N_LOCK));

  a_r1_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_pa == '0));

  a_r1_hit_acked: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_ack);

endmodule

bind rtlb_top rtlb_chk #(
  .N_ENT(N_ENT), .N_LOCK(N_LOCK), .PA_W(PA_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_slot   (cmd_slot),
  .cmd_busy   (cmd_busy),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .lk_ack     (lk_ack),
  .lk_hit     (lk_hit),
  .lk_pa      (lk_pa),
  .rr_ptr     (rr_ptr),
  .victim     (victim),
  .fill       (fill)
);

// File: tb/rtlb_top_test.sv
`timescale 1ns/1ps
module rtlb_top_test;

  localparam int VA_W = 64;
  localparam int PA_W = 64;
  localparam logic [63:0] OPB = 64'h3B58_0000_8765_2469;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [63:0] cmd_addr = '0, cmd_opa = '0, cmd_opb = '0;
  logic        cmd_force = 1'b0;
  logic [3:0]  cmd_slot = '0;
  logic [15:0] cmd_len = '0;
  logic        cmd_busy, rsp_valid;
  logic [1:0]  rsp_status;
  logic        lk_req = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        lk_ack, lk_hit;
  logic [63:0] lk_pa;
  logic [41:0] lk_prot;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtlb_top uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_opa(cmd_opa), .cmd_opb(cmd_opb),
    .cmd_force(cmd_force), .cmd_slot(cmd_slot), .cmd_len(cmd_len),
    .cmd_busy(cmd_busy), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_ack(lk_ack), .lk_hit(lk_hit),
    .lk_pa(lk_pa), .lk_prot(lk_prot)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] addr;
    logic [63:0] opa;
    logic        frc;
    logic [3:0]  slot;
    logic [15:0] len;
    logic [63:0] la;
    logic        ehit;
    logic [63:0] epa;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{3'd1, 64'h10000,   64'h1000,  1'b0, 4'd0, 16'd0, 64'h10234,   1'b1, 64'h80234},
    '{3'd1, 64'h400000,  64'h20002, 1'b0, 4'd0, 16'd0, 64'h40F00C,  1'b1, 64'h100F00C},
    '{3'd0, 64'h0,       64'h0,     1'b0, 4'd0, 16'd0, 64'h410000,  1'b0, 64'h0},
    '{3'd4, 64'h1000,    64'h3000,  1'b0, 4'd1, 16'd3, 64'h1002FFF, 1'b1, 64'h3002FFF},
    '{3'd3, 64'h0,       64'h0,     1'b0, 4'd0, 16'd0, 64'h1001000, 1'b1, 64'h3001000},
    '{3'd0, 64'h0,       64'h0,     1'b0, 4'd0, 16'd0, 64'h10234,   1'b0, 64'h0},
    '{3'd2, 64'h1000000, 64'h0,     1'b0, 4'd0, 16'd0, 64'h1000004, 1'b1, 64'h3000004},
    '{3'd2, 64'h1001000, 64'h0,     1'b1, 4'd0, 16'd0, 64'h1000004, 1'b0, 64'h0}
  };

  function automatic logic [41:0] exp_prot(input logic [63:0] w);
    return {w[61], w[60], w[59], w[58:56], w[55:54], w[53:52], w[51], w[31:1]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [63:0] addr,
                      input logic [63:0] opa, input bit frc, input logic [3:0] slot,
                      input logic [15:0] len, output logic [1:0] st, output int lat);
    @(negedge clk);
    cmd_op = op; cmd_addr = addr; cmd_opa = opa; cmd_opb = OPB;
    cmd_force = frc; cmd_slot = slot; cmd_len = len; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 6) begin
      @(posedge clk); #1;
      lat++;
    end
    st = rsp_status;
  endtask

  task automatic look(input logic [63:0] a, output logic h, output logic [63:0] pa,
                      output logic [41:0] pr);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(posedge clk); #1;
    lk_req = 1'b0;
    h = lk_hit; pa = lk_pa; pr = lk_prot;
  endtask

  task automatic expect_map(input string req, input logic [63:0] a,
                            input bit eh, input logic [63:0] epa);
    logic h; logic [63:0] pa; logic [41:0] pr;
    look(a, h, pa, pr);
    chk(h == eh, req, {63'd0, h}, {63'd0, eh});
    if (eh) chk(pa == epa, req, pa, epa);
    else    chk(pa == 64'd0, req, pa, 64'd0);
  endtask

  task automatic ins(input logic [63:0] va, input logic [63:0] opa);
    logic [1:0] st; int lat;
    send(3'd1, va, opa, 1'b0, 4'd0, 16'd0, st, lat);
    chk(st == 2'd0 && lat == 2, "R12 insert latency", {32'd0, 30'd0, st} + 64'(lat), 64'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] st; int lat;
    logic h; logic [63:0] pa; logic [41:0] pr;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R13 reset state
    chk(cmd_busy == 1'b0 && rsp_valid == 1'b0, "R13 idle after reset",
        {62'd0, cmd_busy, rsp_valid}, 64'd0);
    look(64'h0, h, pa, pr);
    chk(h == 1'b0 && lk_ack == 1'b1, "R13 empty after reset", {62'd0, h, lk_ack}, 64'd1);

    // table walk: R1 R3 R4 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      if (VT[v].op != 3'd0) begin
        send(VT[v].op, VT[v].addr, VT[v].opa, VT[v].frc, VT[v].slot, VT[v].len, st, lat);
        chk(st == 2'd0, "R11 status ok", {62'd0, st}, 64'd0);
        chk(lat == ((VT[v].op == 3'd1) ? 2 : 1), "R12 response latency",
            64'(lat), (VT[v].op == 3'd1) ? 64'd2 : 64'd1);
      end
      look(VT[v].la, h, pa, pr);
      chk(h == VT[v].ehit, "R1 R7 R8 table hit", {63'd0, h}, {63'd0, VT[v].ehit});
      chk(pa == VT[v].epa, "R1 R3 R9 table address", pa, VT[v].epa);
      chk(pr == (VT[v].ehit ? exp_prot(OPB) : 42'd0), "R4 protection fields",
          {22'd0, pr}, VT[v].ehit ? {22'd0, exp_prot(OPB)} : 64'd0);
    end

    // R2 R5 pinned slot wins and survives an overlapping insert; R10 pinned purge
    send(3'd4, 64'h50, 64'h70, 1'b0, 4'd0, 16'd1, st, lat);
    chk(st == 2'd0, "R9 pinned write ok", {62'd0, st}, 64'd0);
    ins(64'h50000, 64'h1200);
    expect_map("R2 R5 pinned entry takes priority", 64'h50008, 1'b1, 64'h70008);
    send(3'd5, 64'h0, 64'h0, 1'b0, 4'd0, 16'd0, st, lat);
    chk(st == 2'd0, "R10 pinned purge ok", {62'd0, st}, 64'd0);
    expect_map("R10 pinned purge exposes insert", 64'h50008, 1'b1, 64'h90008);

    // R5 insert purges overlapping unpinned entry
    ins(64'h23000, 64'h1400);
    ins(64'h20000, 64'h1802);
    expect_map("R5 overlap replaced", 64'h23010, 1'b1, 64'hC3010);

    // R3 unaligned start, 16 KB size
    ins(64'h33ABC, 64'h1C01);
    expect_map("R3 aligned start", 64'h30004, 1'b1, 64'hE0004);
    expect_map("R3 last byte", 64'h33FFF, 1'b1, 64'hE3FFF);
    expect_map("R3 past end", 64'h34000, 1'b0, 64'h0);

    // R9 R10 R11 bad arguments and ops
    send(3'd4, 64'h60, 64'h61, 1'b0, 4'd4, 16'd1, st, lat);
    chk(st == 2'd1, "R9 unpinned slot rejected", {62'd0, st}, 64'd1);
    send(3'd4, 64'h60, 64'h61, 1'b0, 4'd2, 16'd0, st, lat);
    chk(st == 2'd1, "R9 zero length rejected", {62'd0, st}, 64'd1);
    expect_map("R9 rejected write has no effect", 64'h60000, 1'b0, 64'h0);
    send(3'd5, 64'h0, 64'h0, 1'b0, 4'd9, 16'd0, st, lat);
    chk(st == 2'd1, "R10 bad slot rejected", {62'd0, st}, 64'd1);
    send(3'd7, 64'h0, 64'h0, 1'b0, 4'd0, 16'd0, st, lat);
    chk(st == 2'd2, "R11 unknown op 7", {62'd0, st}, 64'd2);
    send(3'd6, 64'h20000, 64'h0, 1'b1, 4'd0, 16'd0, st, lat);
    chk(st == 2'd2, "R11 unknown op 6", {62'd0, st}, 64'd2);
    expect_map("R11 unknown op changes nothing", 64'h23010, 1'b1, 64'hC3010);

    // R12 command during busy is ignored
    @(negedge clk);
    cmd_op = 3'd1; cmd_addr = 64'h45000; cmd_opa = 64'h1600; cmd_opb = OPB;
    cmd_force = 1'b0; cmd_valid = 1'b1;
    @(posedge clk); #1;
    chk(cmd_busy == 1'b1 && rsp_valid == 1'b0, "R12 busy during write step",
        {62'd0, cmd_busy, rsp_valid}, 64'd2);
    cmd_op = 3'd3;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    chk(cmd_busy == 1'b0 && rsp_valid == 1'b1, "R12 insert response",
        {62'd0, cmd_busy, rsp_valid}, 64'd1);
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R12 no response for ignored command", {63'd0, rsp_valid}, 64'd0);
    expect_map("R12 inserted while busy", 64'h45000, 1'b1, 64'hB0000);
    expect_map("R12 ignored purge-all", 64'h23010, 1'b1, 64'hC3010);

    // R6 R7 R8 round robin over unpinned slots
    send(3'd4, 64'h9000, 64'h9100, 1'b0, 4'd3, 16'd2, st, lat);
    send(3'd3, 64'h0, 64'h0, 1'b0, 4'd0, 16'd0, st, lat);
    expect_map("R8 pinned survives purge-all", 64'h9001FF0, 1'b1, 64'h9101FF0);
    expect_map("R9 pinned length end", 64'h9002000, 1'b0, 64'h0);
    expect_map("R8 unpinned cleared", 64'h45000, 1'b0, 64'h0);
    for (int i = 0; i < 13; i++) ins(64'h8000000 + 64'(i) * 64'h1000, 64'h80000 + 64'(i) * 64'h20);
    expect_map("R6 oldest replaced", 64'h8000000, 1'b0, 64'h0);
    expect_map("R6 next kept", 64'h8001000, 1'b1, 64'h4001000);
    expect_map("R6 new entry", 64'h800C000, 1'b1, 64'h400C000);
    ins(64'h800D000, 64'h80000 + 64'd13 * 64'h20);
    expect_map("R6 pointer advanced", 64'h8001000, 1'b0, 64'h0);
    expect_map("R6 later kept", 64'h8002000, 1'b1, 64'h4002000);

    send(3'd3, 64'h0, 64'h0, 1'b0, 4'd0, 16'd0, st, lat);
    for (int i = 0; i < 13; i++) ins(64'h8000000 + 64'(i) * 64'h1000, 64'h80000 + 64'(i) * 64'h20);
    expect_map("R8 pointer restarted", 64'h8000000, 1'b0, 64'h0);
    expect_map("R8 second slot kept", 64'h8001000, 1'b1, 64'h4001000);

    send(3'd2, 64'h8001001, 64'h0, 1'b0, 4'd0, 16'd0, st, lat);
    chk(st == 2'd0, "R7 purge status", {62'd0, st}, 64'd0);
    expect_map("R7 first page purged", 64'h8001000, 1'b0, 64'h0);
    expect_map("R7 last page purged", 64'h8004FFF, 1'b0, 64'h0);
    expect_map("R7 beyond range kept", 64'h8005000, 1'b1, 64'h4005000);
    expect_map("R7 far entry kept", 64'h800C000, 1'b1, 64'h400C000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule